// File: doc/BRIEF.md
# System Bus Address Decoder

This block sits on the processor side of a system controller and sorts every bus cycle into the target it belongs to. When the bus announces a new cycle with an address strobe, the decoder captures the address, the read/write command and the current window settings. In the following clock it presents a one-hot region select, the direction of the cycle and the offset of the address inside the selected region. It can also report that no region claimed the address.

There are three regions. The configuration register window has a fixed 4 KB base at 0x1000_0000, so boot code can reach it before anything has been set up. The boot PROM/flash window starts at 0x1FC0_0000, and its length follows a 2-bit device-size code. The SDRAM window is defined by a base value, a mask and an enable bit. When windows overlap, a fixed priority settles which region is selected.

Top module: `sysbus_addr_decoder`

## Requirements
- R1: Results are registered. `decodeValid` is high during exactly the one clock cycle after a clock edge that sampled `addrStrobe` high. In every other cycle, `regionSel` is 0, `noHit` is 0 and `regionOffset` is 0.
- R2: An address whose bits [31:12] equal 0x10000 selects the configuration window: `regionSel` = 3'b001 (bit 0), with `regionOffset` = address[11:0]. This holds out of reset, whatever the other settings are.
- R3: The PROM window begins at 0x1FC0_0000. Its length is 512 KB, 1 MB, 2 MB or 4 MB for `promSizeSel` codes 0, 1, 2 and 3. A hit gives `regionSel` = 3'b010 (bit 1), with the offset equal to the address minus 0x1FC0_0000.
- R4: When the SDRAM window is enabled and (address AND `sdramMask`) equals `sdramBase`, `regionSel` = 3'b100 (bit 2) and the offset is address AND NOT `sdramMask`.
- R5: While `sdramEnable` is 0, the SDRAM window never matches, whatever the base and mask are.
- R6: Overlapping windows are resolved as configuration window over PROM, and PROM over SDRAM.
- R7: An address that no window claims sets `noHit` for exactly one cycle. In that cycle `regionSel` = 0 and the offset is 0.
- R8: The address, the command (`busWrite` = 1 for a write) and the window settings are all taken at the strobe edge. `isWrite` reflects the captured command. Changes on the bus after the strobe do not alter the result.
- R9: At most one bit of `regionSel` is high at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| addrStrobe | input | 1 | Start of a bus cycle; the bus is captured on this edge |
| busAddr | input | 32 | Bus address |
| busWrite | input | 1 | Command: 1 for a write, 0 for a read |
| promSizeSel | input | 2 | PROM size code: 0 = 512 KB, 1 = 1 MB, 2 = 2 MB, 3 = 4 MB |
| sdramBase | input | 32 | SDRAM window base value |
| sdramMask | input | 32 | SDRAM window compare mask |
| sdramEnable | input | 1 | Enables the SDRAM window |
| decodeValid | output | 1 | Result valid for this cycle |
| regionSel | output | 3 | One-hot select: bit 0 config, bit 1 PROM, bit 2 SDRAM |
| isWrite | output | 1 | Captured command direction |
| regionOffset | output | 32 | Address offset within the selected region |
| noHit | output | 1 | No window claimed the address |

## Verification
All outputs of the block are due exactly one clock after the edge that samples the strobe, and they return to zero one clock after that. The driver stamps each expected result with the cycle number in which it is due. The monitor compares the outputs at the falling edge of that cycle only, and it requires idle outputs in every other cycle. Because of this, a result that arrives one cycle early or one cycle late counts as both a mismatch and a stray output. Between strobes the bus address is filled with noise, so any dependence on the live bus shows up in the results.

// File: rtl/busdec_pkg.sv
package busdec_pkg;
  localparam int REGION_N = 3;
  localparam int IDX_CFG   = 0;
  localparam int IDX_PROM  = 1;
  localparam int IDX_SDRAM = 2;

  // strobes from control to datapath
  typedef struct packed {
    logic capture;  // take a new bus snapshot this edge
    logic present;  // drive the decoded result on the outputs
  } decCtrl_t;
endpackage

// File: rtl/busdec_ctrl.sv
module busdec_ctrl
  import busdec_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     addrStrobe,
  output decCtrl_t ctrl
);
  logic validQ;

  always_ff @(posedge clk) begin
    if (!rstN) validQ <= 1'b0;
    else       validQ <= addrStrobe;
  end

  always_comb begin
    ctrl.capture = addrStrobe & rstN;
    ctrl.present = validQ;
  end
endmodule

// File: rtl/busdec_path.sv
module busdec_path
  import busdec_pkg::*;
#(
  parameter int                ADDR_W        = 32,
  parameter logic [ADDR_W-1:0] CFG_BASE      = 32'h1000_0000,
  parameter int                CFG_WIN_BITS  = 12,
  parameter logic [ADDR_W-1:0] PROM_BASE     = 32'h1FC0_0000,
  parameter int                PROM_MIN_BITS = 19,
  parameter int                SIZE_SEL_W    = 2
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  decCtrl_t              ctrl,
  input  logic [ADDR_W-1:0]     busAddr,
  input  logic                  busWrite,
  input  logic [SIZE_SEL_W-1:0] promSizeSel,
  input  logic [ADDR_W-1:0]     sdramBase,
  input  logic [ADDR_W-1:0]     sdramMask,
  input  logic                  sdramEnable,
  output logic [REGION_N-1:0]   regionSel,
  output logic                  isWrite,
  output logic [ADDR_W-1:0]     regionOffset,
  output logic                  noHit
);
  localparam int PROM_CODES = 1 << SIZE_SEL_W;
  localparam int CFG_TAG_W  = ADDR_W - CFG_WIN_BITS;

  logic [ADDR_W-1:0]     addrQ, baseQ, maskQ;
  logic [SIZE_SEL_W-1:0] sizeQ;
  logic                  writeQ, enableQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ   <= '0;
      baseQ   <= '0;
      maskQ   <= '0;
      sizeQ   <= '0;
      writeQ  <= 1'b0;
      enableQ <= 1'b0;
    end else if (ctrl.capture) begin
      addrQ   <= busAddr;
      baseQ   <= sdramBase;
      maskQ   <= sdramMask;
      sizeQ   <= promSizeSel;
      writeQ  <= busWrite;
      enableQ <= sdramEnable;
    end
  end

  // low-bit mask of the PROM window for every size code
  logic [ADDR_W-1:0] promLowTab [PROM_CODES];
  for (genvar g = 0; g < PROM_CODES; g++) begin : g_promSize
    assign promLowTab[g] = (ADDR_W'(1) << (PROM_MIN_BITS + g)) - ADDR_W'(1);
  end

  logic [ADDR_W-1:0] promLow;
  logic              cfgHit, promHit, sdramHit;
  logic [CFG_TAG_W-1:0] cfgTag;

  assign promLow  = promLowTab[sizeQ];
  assign cfgTag   = CFG_BASE[ADDR_W-1:CFG_WIN_BITS];
  assign cfgHit   = addrQ[ADDR_W-1:CFG_WIN_BITS] == cfgTag;
  assign promHit  = (addrQ & ~promLow) == (PROM_BASE & ~promLow);
  assign sdramHit = enableQ && ((addrQ & maskQ) == baseQ);

  logic [REGION_N-1:0] selRaw;
  logic [ADDR_W-1:0]   offRaw;

  always_comb begin
    selRaw = '0;
    offRaw = '0;
    if (cfgHit) begin
      selRaw[IDX_CFG] = 1'b1;
      offRaw = addrQ & ((ADDR_W'(1) << CFG_WIN_BITS) - ADDR_W'(1));
    end else if (promHit) begin
      selRaw[IDX_PROM] = 1'b1;
      offRaw = addrQ & promLow;
    end else if (sdramHit) begin
      selRaw[IDX_SDRAM] = 1'b1;
      offRaw = addrQ & ~maskQ;
    end
  end

  assign regionSel    = ctrl.present ? selRaw : '0;
  assign regionOffset = ctrl.present ? offRaw : '0;
  assign isWrite      = ctrl.present & writeQ;
  assign noHit        = ctrl.present & (selRaw == '0);
endmodule

// File: rtl/sysbus_addr_decoder.sv
module sysbus_addr_decoder
  import busdec_pkg::*;
#(
  parameter int                ADDR_W        = 32,
  parameter logic [ADDR_W-1:0] CFG_BASE      = 32'h1000_0000,
  parameter int                CFG_WIN_BITS  = 12,
  parameter logic [ADDR_W-1:0] PROM_BASE     = 32'h1FC0_0000,
  parameter int                PROM_MIN_BITS = 19,
  parameter int                SIZE_SEL_W    = 2
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  addrStrobe,
  input  logic [ADDR_W-1:0]     busAddr,
  input  logic                  busWrite,
  input  logic [SIZE_SEL_W-1:0] promSizeSel,
  input  logic [ADDR_W-1:0]     sdramBase,
  input  logic [ADDR_W-1:0]     sdramMask,
  input  logic                  sdramEnable,
  output logic                  decodeValid,
  output logic [REGION_N-1:0]   regionSel,
  output logic                  isWrite,
  output logic [ADDR_W-1:0]     regionOffset,
  output logic                  noHit
);
  decCtrl_t ctrl;

  busdec_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .addrStrobe(addrStrobe),
    .ctrl      (ctrl)
  );

  busdec_path #(
    .ADDR_W       (ADDR_W),
    .CFG_BASE     (CFG_BASE),
    .CFG_WIN_BITS (CFG_WIN_BITS),
    .PROM_BASE    (PROM_BASE),
    .PROM_MIN_BITS(PROM_MIN_BITS),
    .SIZE_SEL_W   (SIZE_SEL_W)
  ) u_path (
    .clk         (clk),
    .rstN        (rstN),
    .ctrl        (ctrl),
    .busAddr     (busAddr),
    .busWrite    (busWrite),
    .promSizeSel (promSizeSel),
    .sdramBase   (sdramBase),
    .sdramMask   (sdramMask),
    .sdramEnable (sdramEnable),
    .regionSel   (regionSel),
    .isWrite     (isWrite),
    .regionOffset(regionOffset),
    .noHit       (noHit)
  );

  assign decodeValid = ctrl.present;
endmodule

// File: rtl/busdec_checker.sv
module busdec_checker #(
  parameter int                ADDR_W       = 32,
  parameter logic [ADDR_W-1:0] CFG_BASE     = 32'h1000_0000,
  parameter int                CFG_WIN_BITS = 12
) (
  input logic              clk,
  input logic              rstN,
  input logic              addrStrobe,
  input logic [ADDR_W-1:0] busAddr,
  input logic              sdramEnable,
  input logic              decodeValid,
  input logic [2:0]        regionSel,
  input logic              noHit
);
  AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rstN)
    addrStrobe |=> decodeValid);  // R1
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !decodeValid |-> (regionSel == 3'b000 && !noHit));  // R1
  AST_CFG_FIXED: assert property (@(posedge clk) disable iff (!rstN)
    (addrStrobe && busAddr[ADDR_W-1:CFG_WIN_BITS] == CFG_BASE[ADDR_W-1:CFG_WIN_BITS])
    |=> regionSel == 3'b001);  // R2
  AST_SDRAM_GATED: assert property (@(posedge clk) disable iff (!rstN)
    (addrStrobe && !sdramEnable) |=> !regionSel[2]);  // R5
  AST_NOHIT_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    noHit |-> regionSel == 3'b000);  // R7
  AST_ONE_REGION: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(regionSel));  // R9
endmodule

bind sysbus_addr_decoder busdec_checker #(
  .ADDR_W      (ADDR_W),
  .CFG_BASE    (CFG_BASE),
  .CFG_WIN_BITS(CFG_WIN_BITS)
) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .addrStrobe (addrStrobe),
  .busAddr    (busAddr),
  .sdramEnable(sdramEnable),
  .decodeValid(decodeValid),
  .regionSel  (regionSel),
  .noHit      (noHit)
);

// File: tb/sysbus_addr_decoder_test.sv
module sysbus_addr_decoder_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        addrStrobe = 1'b0;
  logic [31:0] busAddr = '0;
  logic        busWrite = 1'b0;
  logic [1:0]  promSizeSel = '0;
  logic [31:0] sdramBase = '0;
  logic [31:0] sdramMask = '0;
  logic        sdramEnable = 1'b0;
  logic        decodeValid;
  logic [2:0]  regionSel;
  logic        isWrite;
  logic [31:0] regionOffset;
  logic        noHit;

  int testsRun = 0;
  int testsFailed = 0;
  int cyc = 0;
  bit finished = 0;

  typedef struct {
    logic [2:0]  sel;
    logic [31:0] off;
    logic        wr;
    logic        nh;
    int          due;
    string       tag;
  } expItem_t;

  expItem_t scoreQ[$];

  sysbus_addr_decoder uut (
    .clk(clk), .rstN(rstN), .addrStrobe(addrStrobe), .busAddr(busAddr),
    .busWrite(busWrite), .promSizeSel(promSizeSel), .sdramBase(sdramBase),
    .sdramMask(sdramMask), .sdramEnable(sdramEnable), .decodeValid(decodeValid),
    .regionSel(regionSel), .isWrite(isWrite), .regionOffset(regionOffset),
    .noHit(noHit)
  );

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string tag, input string act, input string exp);
    testsRun++;
    if (!ok) begin
      testsFailed++;
      $display("FAIL %s: actual %s expected %s", tag, act, exp);
    end
  endtask

  // expected result straight from the requirements
  function automatic expItem_t predict(input logic [31:0] a, input logic wr, input logic [1:0] sz,
                                       input logic [31:0] b, input logic [31:0] m, input logic en);
    expItem_t e;
    logic [31:0] low;
    low = (32'h1 << (19 + sz)) - 32'h1;
    e.wr = wr; e.nh = 1'b0;
    if (a[31:12] == 20'h10000) begin
      e.sel = 3'b001; e.off = {20'h0, a[11:0]};
    end else if (a >= 32'h1FC0_0000 && a <= 32'h1FC0_0000 + low) begin
      e.sel = 3'b010; e.off = a - 32'h1FC0_0000;
    end else if (en && ((a & m) == b)) begin
      e.sel = 3'b100; e.off = a & ~m;
    end else begin
      e.sel = 3'b000; e.off = 32'h0; e.nh = 1'b1;
    end
    return e;
  endfunction

  task automatic drive(input logic [31:0] a, input logic wr, input logic [1:0] sz,
                       input logic [31:0] b, input logic [31:0] m, input logic en, input string tag);
    expItem_t e;
    @(negedge clk);
    busAddr = a; busWrite = wr; promSizeSel = sz;
    sdramBase = b; sdramMask = m; sdramEnable = en; addrStrobe = 1'b1;
    e = predict(a, wr, sz, b, m, en);
    e.due = cyc + 1;
    e.tag = tag;
    scoreQ.push_back(e);
  endtask

  // bus noise between cycles (R8)
  task automatic idle(input int n);
    repeat (n) begin
      @(negedge clk);
      addrStrobe = 1'b0;
      busAddr = $urandom;
      busWrite = $urandom;
      promSizeSel = $urandom;
      sdramEnable = 1'b1;
      sdramMask = 32'h0; sdramBase = 32'h0;
    end
  endtask

  // monitor
  always @(negedge clk) begin
    if (rstN && !finished) begin
      if (scoreQ.size() > 0 && scoreQ[0].due == cyc) begin
        expItem_t e;
        e = scoreQ.pop_front();
        check(decodeValid && regionSel == e.sel && regionOffset == e.off &&
              isWrite == e.wr && noHit == e.nh, e.tag,
              $sformatf("v=%0b sel=%b off=%h wr=%0b nh=%0b", decodeValid, regionSel, regionOffset, isWrite, noHit),
              $sformatf("v=1 sel=%b off=%h wr=%0b nh=%0b", e.sel, e.off, e.wr, e.nh));
      end else begin
        check(!decodeValid && regionSel == 3'b000 && !noHit && regionOffset == 32'h0, "R1 idle",
              $sformatf("v=%0b sel=%b nh=%0b off=%h", decodeValid, regionSel, noHit, regionOffset),
              "v=0 sel=000 nh=0 off=0");
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(!decodeValid && regionSel == 3'b000 && !noHit, "R1 reset",
          $sformatf("v=%0b sel=%b nh=%0b", decodeValid, regionSel, noHit), "all zero");
    rstN = 1'b1;
    // R2: config window straight out of reset, SDRAM set to claim everything (R6)
    drive(32'h1000_0ABC, 1'b1, 2'd0, 32'h0, 32'h0, 1'b1, "R2 R6 cfg over sdram");
    idle(2);
    drive(32'h1000_0FFF, 1'b0, 2'd3, 32'h0, 32'h0, 1'b0, "R2 cfg top");
    drive(32'h1000_1000, 1'b0, 2'd3, 32'h0, 32'h0, 1'b0, "R7 just past cfg");
    idle(1);
    // R3: PROM sizes
    drive(32'h1FC7_FFFC, 1'b0, 2'd0, 32'h0, 32'h0, 1'b0, "R3 512K last word");
    drive(32'h1FC8_0000, 1'b0, 2'd0, 32'h0, 32'h0, 1'b0, "R3 R7 512K beyond");
    drive(32'h1FC8_0000, 1'b1, 2'd1, 32'h0, 32'h0, 1'b0, "R3 1M");
    drive(32'h1FDF_FFF0, 1'b0, 2'd2, 32'h0, 32'h0, 1'b0, "R3 2M");
    drive(32'h1FFF_FFFC, 1'b0, 2'd2, 32'h0, 32'h0, 1'b0, "R3 R7 2M beyond");
    drive(32'h1FFF_FFFC, 1'b1, 2'd3, 32'h0, 32'h0, 1'b0, "R3 4M");
    drive(32'h1FBF_FFFC, 1'b0, 2'd3, 32'h0, 32'h0, 1'b0, "R3 R7 below base");
    idle(2);
    // R4 / R5 / R6: SDRAM window
    drive(32'h0123_4568, 1'b1, 2'd0, 32'h0000_0000, 32'hF000_0000, 1'b1, "R4 sdram low");
    drive(32'h1000_1000, 1'b0, 2'd0, 32'h1000_0000, 32'hF000_0000, 1'b1, "R4 sdram near cfg");
    drive(32'h1FC0_0010, 1'b0, 2'd0, 32'h1000_0000, 32'hF000_0000, 1'b1, "R6 prom over sdram");
    drive(32'h1000_1000, 1'b0, 2'd0, 32'h1000_0000, 32'hF000_0000, 1'b0, "R5 sdram disabled");
    drive(32'h8000_0040, 1'b1, 2'd0, 32'h8000_0000, 32'hFF00_0000, 1'b0, "R5 sdram disabled hi");
    drive(32'h8000_0040, 1'b1, 2'd0, 32'h8000_0000, 32'hFF00_0000, 1'b1, "R4 R8 sdram write");
    idle(1);
    drive(32'h4000_0000, 1'b0, 2'd1, 32'h8000_0000, 32'hFF00_0000, 1'b1, "R7 miss");
    idle(1);
    drive(32'h4000_0000, 1'b0, 2'd1, 32'h8000_0000, 32'hFF00_0000, 1'b1, "R7 miss again");
    idle(4);
    check(scoreQ.size() == 0, "R1 all results seen", $sformatf("%0d left", scoreQ.size()), "0 left");
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    #200000;
    if (!finished) begin
      finished = 1;
      testsRun++;
      testsFailed++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end
endmodule